// File: doc/BRIEF.md
# Address-less Local Exclusive Monitor

This block is the exclusive-access monitor that sits beside one processor core in a single-core system. It remembers one thing: whether an exclusive load has been issued and not yet used up. It stores no address, so the reservation covers the whole address space. After an exclusive load, the next exclusive store passes whatever address it targets.

Each access type arrives as a one-cycle strobe: exclusive load, exclusive store, clear-exclusive and ordinary store. An address bus also comes in, but the block does not look at it. On an exclusive-store strobe, the block gives a one-bit status in the same cycle (0 means pass, 1 means fail). It also raises a write-enable that lets the memory write go ahead. The memory itself is outside this block, as are any other bus masters and any global monitor.

Top module: `excl_monitor`

## Requirements
- R1: After reset the monitor is open (no reservation). An exclusive store issued first after reset fails.
- R2: An exclusive store that follows an exclusive load passes: status 0 and write-enable 1 in the cycle of its strobe. This holds whatever value the address input carries on either access.
- R3: A failing exclusive store returns status 1 and keeps write-enable at 0.
- R4: The first exclusive store after an exclusive load ends the reservation, so a second exclusive store with no new load in between fails.
- R5: A clear-exclusive strobe between an exclusive load and an exclusive store makes that store fail.
- R6: Ordinary stores, any number and at any address, issued between an exclusive load and an exclusive store leave the reservation in place. The exclusive store still passes.
- R7: When an exclusive load and a clear-exclusive arrive in the same cycle, the clear wins and the monitor ends up open.
- R8: Status and write-enable depend only on the exclusive-store strobe and the current state, with no added cycle of latency. While the exclusive-store strobe is low, both outputs are 0.
- R9: When an exclusive store and an exclusive load arrive in the same cycle, the store is judged on the state held before that cycle, and a reservation is held afterwards. When an exclusive store and a clear arrive together, the store is judged on the prior state and the monitor is open afterwards.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_excl | input | 1 | Exclusive load strobe |
| st_excl | input | 1 | Exclusive store strobe |
| clr_excl | input | 1 | Clear-exclusive strobe |
| st_plain | input | 1 | Ordinary store strobe |
| addr | input | ADDR_W | Access address (ignored) |
| st_status | output | 1 | Exclusive store result, 0 pass and 1 fail |
| st_wr_en | output | 1 | Enables the memory write of an exclusive store |

## Verification
The hardest cases to reach from the ports are strobes that coincide in one cycle, such as load with clear, or store with load or clear. There the result depends on the priority between strobes and on the order of judging and updating. The bench reaches them by sweeping every combination of the four strobes across two consecutive cycles, starting from a known open state. After each pair it sends an exclusive-store probe, which exposes the state the pair left behind. Random-looking address values on every access show that the address has no effect.

// File: rtl/excl_monitor.sv
module excl_monitor #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_excl,
  input  logic              st_excl,
  input  logic              clr_excl,
  input  logic              st_plain,
  input  logic [ADDR_W-1:0] addr,
  output logic              st_status,
  output logic              st_wr_en
);

  typedef enum logic {MON_OPEN = 1'b0, MON_EXCL = 1'b1} mon_state_t;

  mon_state_t state_q, state_d;
  logic       addr_unused;
  logic       plain_unused;

  assign addr_unused  = ^addr;
  assign plain_unused = st_plain;

  assign st_wr_en  = st_excl && (state_q == MON_EXCL);
  assign st_status = st_excl && (state_q != MON_EXCL);

  always_comb begin
    state_d = state_q;
    if (clr_excl)
      state_d = MON_OPEN;
    else if (ld_excl)
      state_d = MON_EXCL;
    else if (st_excl)
      state_d = MON_OPEN;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state_q <= MON_OPEN;
    else        state_q <= state_d;
  end

endmodule

module excl_monitor_chk (
  input logic clk,
  input logic rst_n,
  input logic ld_excl,
  input logic st_excl,
  input logic clr_excl,
  input logic st_status,
  input logic st_wr_en
);

  a_r3_fail_nowrite: assert property (@(posedge clk) disable iff (!rst_n)
    (st_excl && st_status) |-> !st_wr_en);

  a_r2_load_then_pass: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_excl && !clr_excl) |=> (st_excl |-> (st_wr_en && !st_status)));

  a_r4_second_fails: assert property (@(posedge clk) disable iff (!rst_n)
    (st_excl && !ld_excl) |=> (st_excl |-> st_status));

  a_r5_clear_fails: assert property (@(posedge clk) disable iff (!rst_n)
    clr_excl |=> (st_excl |-> st_status));

  a_r8_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
    !st_excl |-> (!st_wr_en && !st_status));

endmodule

bind excl_monitor excl_monitor_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ld_excl(ld_excl), .st_excl(st_excl),
  .clr_excl(clr_excl), .st_status(st_status), .st_wr_en(st_wr_en)
);

// File: tb/excl_monitor_bench.sv
module excl_monitor_bench;
  localparam int AW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ld, st, clr, pst;
  logic [AW-1:0] addr;
  logic st_status, st_wr_en;
  int total = 0;
  int bad = 0;
  bit model_res = 1'b0;
  logic [AW-1:0] lfsr = 16'hACE1;

  always #5 clk = ~clk;

  excl_monitor #(.ADDR_W(AW)) u_excl_monitor (
    .clk(clk), .rst_n(rst_n), .ld_excl(ld), .st_excl(st), .clr_excl(clr),
    .st_plain(pst), .addr(addr), .st_status(st_status), .st_wr_en(st_wr_en)
  );

  task automatic check(input string req, input logic act_s, input logic act_w,
                       input logic exp_s, input logic exp_w);
    total++;
    if (act_s !== exp_s || act_w !== exp_w) begin
      bad++;
      $display("FAIL %s: status=%b wr_en=%b expected status=%b wr_en=%b",
               req, act_s, act_w, exp_s, exp_w);
    end
  endtask

  // one cycle of strobes {ld,st,clr,pst}; outputs checked against model, then model advanced
  task automatic step(input logic [3:0] s, input string req);
    @(negedge clk);
    lfsr = {lfsr[AW-2:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    {ld, st, clr, pst} = s;
    addr = lfsr;
    #2;
    check(req, st_status, st_wr_en, st && !model_res, st && model_res);
    if (clr) model_res = 1'b0;
    else if (ld) model_res = 1'b1;
    else if (st) model_res = 1'b0;
  endtask

  initial begin
    {ld, st, clr, pst} = 4'b0;
    addr = '0;
    repeat (3) @(posedge clk);
    #2;
    check("R8 reset idle", st_status, st_wr_en, 1'b0, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;

    step(4'b0100, "R1 store after reset fails");
    step(4'b1000, "R2 load");
    step(4'b0100, "R2 store other addr passes");
    step(4'b0100, "R4 second store fails");
    step(4'b0100, "R3 fail no write");
    step(4'b1000, "R5 load");
    step(4'b0010, "R5 clear");
    step(4'b0100, "R5 store after clear fails");
    step(4'b1000, "R6 load");
    step(4'b0001, "R6 plain store");
    step(4'b0001, "R6 plain store");
    step(4'b0001, "R6 plain store");
    step(4'b0100, "R6 store still passes");
    step(4'b1010, "R7 load with clear");
    step(4'b0100, "R7 store fails");
    step(4'b1000, "R9 load");
    step(4'b1100, "R9 store with load passes");
    step(4'b0100, "R9 reservation held, passes");
    step(4'b1000, "R9 load");
    step(4'b0110, "R9 store with clear passes");
    step(4'b0100, "R9 then fails");
    step(4'b1000, "R8 load");
    step(4'b0000, "R8 idle outputs low");

    for (int a = 0; a < 16; a++) begin
      for (int b = 0; b < 16; b++) begin
        step(4'b0010, "R7 sweep clear");
        step(4'(a), "R9 sweep first");
        step(4'(b), "R9 sweep second");
        step(4'b0100, "R2 R4 sweep probe");
      end
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #500000;
    total++;
    bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule